// File: doc/BRIEF.md
# Infrared Wake Pattern Comparator

This block holds a short reference infrared pattern and raises a wake signal when a received pattern agrees with it closely enough. Every pattern entry is one byte: bit 7 is the level flag (1 = pulse, 0 = space) and bits 6:0 give the run length in sample periods. Software loads the reference through a data register while a load-enable bit is set, or lets the block capture incoming samples directly while it is in learning mode.

In compare mode every incoming sample is checked against the reference entry at the same position. Once as many samples as the programmed depth have been checked, the block counts how many of them failed to match. If that count does not exceed the programmed tolerance, it sets a sticky wake flag. A count register, a read index and a read-data register let software inspect what is stored. A clear command empties the store, but only in learning mode.

Top module: `irwake_matcher`

## Requirements
- R1: After reset `wake` is low and every readable register (CTRL at address 0, STATUS 1, DEPTH 2, TOL 3, COUNT 4, RIDX 7) reads zero.
- R2: A write to WDATA (address 5) appends the byte as an entry (bit 7 pulse flag, bits 6:0 duration) only while CTRL bit 1 (load enable) is set. Otherwise it leaves the store untouched.
- R3: An entry is rejected if its duration is zero, if it is the first entry and its bit 7 is clear, or if the store already holds N_ENTRIES entries.
- R4: With CTRL bit 0 (compare mode) clear and CTRL bit 1 clear, each valid sample on `smp_data` is appended to the store under the rules of R3. With load enable set, samples are not captured.
- R5: COUNT reads the number of stored entries. RIDX reads the read index. A read of RDATA (address 6) returns the entry at the read index and advances the index, which wraps to 0 after entry COUNT-1.
- R6: A sample matches a reference entry when the pulse flags are equal and the durations differ by at most one period.
- R7: In compare mode, sample k of a sequence is checked against entry k. Positions at or beyond COUNT always mismatch. After DEPTH samples the wake flag is set if the number of mismatches is at most TOL, and the next sequence starts at entry 0. A DEPTH of 0 disables comparison.
- R8: A CTRL write with bit 2 set empties the store and resets the read index, but only when the written bit 0 is 0. Bit 2 always reads back 0.
- R9: Writing 1 to STATUS bit 0 clears the wake flag, and writing 0 there has no effect. If a sequence completes with a match in the same cycle as a clear, the flag stays set. `wake` equals STATUS bit 0.
- R10: Any write to CTRL restarts the compare sequence at entry 0 with no mismatches counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances index on RDATA) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| smp_valid | input | 1 | Received sample strobe |
| smp_data | input | 8 | Received sample: bit 7 pulse, bits 6:0 duration |
| wake | output | 1 | Sticky wake flag |

## Verification
The closing sample of a compare sequence and a software write that clears the wake flag can land on the same clock edge. The bench provokes this by driving the last sample and a STATUS write of 1 together. It does this once with a sequence that matches, where the flag must stay high, and once with a sequence that has too many mismatches, where the flag must drop. A second overlap is a CTRL write arriving in the middle of a sequence. The bench checks that a full matching sequence sent after that write still raises wake, which can only happen if the position was restarted.

// File: rtl/irwake_pkg.sv
package irwake_pkg;
  localparam int DUR_W = 7;

  typedef struct packed {
    logic             pulse;
    logic [DUR_W-1:0] dur;
  } ir_entry_t;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_DEPTH = 3'd2,
    A_TOL   = 3'd3,
    A_COUNT = 3'd4,
    A_WDATA = 3'd5,
    A_RDATA = 3'd6,
    A_RIDX  = 3'd7
  } reg_addr_e;

  // level flags equal and run lengths within slack periods
  function automatic logic entry_close(ir_entry_t a, ir_entry_t b, int unsigned slack);
    logic [DUR_W-1:0] diff;
    diff = (a.dur >= b.dur) ? (a.dur - b.dur) : (b.dur - a.dur);
    return (a.pulse == b.pulse) && (32'(diff) <= slack);
  endfunction
endpackage

// File: rtl/irwake_regs.sv
module irwake_regs
  import irwake_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic             seq_hit,
  output logic             mode_q,
  output logic             load_q,
  output logic [CNT_W-1:0] depth_q,
  output logic [CNT_W-1:0] tol_q,
  output logic             wake_q,
  output logic             clr_cmd,
  output logic             restart,
  output logic             wr_push
);
  logic             mode_d, load_d, wake_d;
  logic [CNT_W-1:0] depth_d, tol_d;
  logic             ctrl_wr, stat_wr;

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign stat_wr = reg_wr && (reg_addr == A_STAT);
  assign restart = ctrl_wr;
  assign clr_cmd = ctrl_wr && reg_wdata[2] && !reg_wdata[0];
  assign wr_push = reg_wr && (reg_addr == A_WDATA) && load_q;

  always_comb begin
    mode_d  = mode_q;
    load_d  = load_q;
    depth_d = depth_q;
    tol_d   = tol_q;
    wake_d  = wake_q;
    if (ctrl_wr) begin
      mode_d = reg_wdata[0];
      load_d = reg_wdata[1];
    end
    if (reg_wr && (reg_addr == A_DEPTH)) depth_d = reg_wdata[CNT_W-1:0];
    if (reg_wr && (reg_addr == A_TOL))   tol_d   = reg_wdata[CNT_W-1:0];
    // set has priority over write-one-to-clear
    if (seq_hit)                         wake_d  = 1'b1;
    else if (stat_wr && reg_wdata[0])    wake_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      load_q  <= 1'b0;
      depth_q <= '0;
      tol_q   <= '0;
      wake_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      load_q  <= load_d;
      depth_q <= depth_d;
      tol_q   <= tol_d;
      wake_q  <= wake_d;
    end
  end
endmodule

// File: rtl/irwake_store.sv
module irwake_store
  import irwake_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int CNT_W     = $clog2(N_ENTRIES + 1),
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  ir_entry_t        push_data,
  input  logic             clr,
  input  logic             rd_adv,
  input  logic [CNT_W-1:0] cmp_idx,
  output logic [CNT_W-1:0] count_q,
  output logic [IDX_W-1:0] rd_idx_q,
  output ir_entry_t        rd_entry,
  output ir_entry_t        ref_entry,
  output logic             ref_ok
);
  ir_entry_t        mem [N_ENTRIES];
  logic [CNT_W-1:0] count_d;
  logic [IDX_W-1:0] rd_idx_d;
  logic             push_ok, not_full, legal;

  assign not_full = (count_q != CNT_W'(N_ENTRIES));
  assign legal    = (push_data.dur != '0) && ((count_q != '0) || push_data.pulse);
  assign push_ok  = push_req && !clr && not_full && legal;

  always_comb begin
    count_d  = count_q;
    rd_idx_d = rd_idx_q;
    if (clr) begin
      count_d  = '0;
      rd_idx_d = '0;
    end else begin
      if (push_ok) count_d = count_q + CNT_W'(1);
      if (rd_adv && (count_q != '0)) begin
        if (CNT_W'(rd_idx_q) == (count_q - CNT_W'(1))) rd_idx_d = '0;
        else                                           rd_idx_d = rd_idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      rd_idx_q <= '0;
    end else begin
      count_q  <= count_d;
      rd_idx_q <= rd_idx_d;
    end
  end

  // storage array carries no reset; only entries below count are ever read
  always_ff @(posedge clk) begin
    if (push_ok) mem[count_q[IDX_W-1:0]] <= push_data;
  end

  assign rd_entry  = (count_q != '0) ? mem[rd_idx_q] : '0;
  assign ref_ok    = (cmp_idx < count_q);
  assign ref_entry = ref_ok ? mem[cmp_idx[IDX_W-1:0]] : '0;
endmodule

// File: rtl/irwake_compare.sv
module irwake_compare
  import irwake_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SLACK = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             smp_valid,
  input  ir_entry_t        smp,
  input  ir_entry_t        ref_entry,
  input  logic             ref_ok,
  input  logic [CNT_W-1:0] depth,
  input  logic [CNT_W-1:0] tol,
  output logic [CNT_W-1:0] ptr_q,
  output logic             seq_hit
);
  logic [CNT_W-1:0] miss_q, miss_d, ptr_d, miss_now;
  logic             step, last, is_match;

  assign step     = en && smp_valid && (depth != '0) && !restart;
  assign is_match = ref_ok && entry_close(smp, ref_entry, SLACK);
  assign miss_now = miss_q + (is_match ? CNT_W'(0) : CNT_W'(1));
  assign last     = (ptr_q == (depth - CNT_W'(1)));
  assign seq_hit  = step && last && (miss_now <= tol);

  always_comb begin
    ptr_d  = ptr_q;
    miss_d = miss_q;
    if (restart) begin
      ptr_d  = '0;
      miss_d = '0;
    end else if (step) begin
      if (last) begin
        ptr_d  = '0;
        miss_d = '0;
      end else begin
        ptr_d  = ptr_q + CNT_W'(1);
        miss_d = miss_now;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      miss_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      miss_q <= miss_d;
    end
  end
endmodule

// File: rtl/irwake_matcher.sv
module irwake_matcher
  import irwake_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int SLACK     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       smp_valid,
  input  logic [7:0] smp_data,
  output logic       wake
);
  localparam int CNT_W = $clog2(N_ENTRIES + 1);
  localparam int IDX_W = $clog2(N_ENTRIES);

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic             mode_q, load_q, wake_q, clr_cmd, restart, wr_push, seq_hit;
  logic             capture, push_req, rd_adv, ref_ok;
  logic [CNT_W-1:0] depth_q, tol_q, count_q, ptr_q;
  logic [IDX_W-1:0] rd_idx_q;
  ir_entry_t        push_data, rd_entry, ref_entry;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  irwake_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .seq_hit(seq_hit), .mode_q(mode_q), .load_q(load_q),
    .depth_q(depth_q), .tol_q(tol_q), .wake_q(wake_q), .clr_cmd(clr_cmd),
    .restart(restart), .wr_push(wr_push)
  );

  assign capture   = smp_valid && !mode_q && !load_q;
  assign push_req  = wr_push || capture;
  assign push_data = wr_push ? ir_entry_t'(reg_wdata) : ir_entry_t'(smp_data);
  assign rd_adv    = reg_rd && (reg_addr == A_RDATA);

  irwake_store #(.N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n_s), .push_req(push_req), .push_data(push_data),
    .clr(clr_cmd), .rd_adv(rd_adv), .cmp_idx(ptr_q), .count_q(count_q),
    .rd_idx_q(rd_idx_q), .rd_entry(rd_entry), .ref_entry(ref_entry), .ref_ok(ref_ok)
  );

  irwake_compare #(.CNT_W(CNT_W), .SLACK(SLACK)) u_cmp (
    .clk(clk), .rst_n(rst_n_s), .en(mode_q), .restart(restart),
    .smp_valid(smp_valid), .smp(ir_entry_t'(smp_data)), .ref_entry(ref_entry),
    .ref_ok(ref_ok), .depth(depth_q), .tol(tol_q), .ptr_q(ptr_q), .seq_hit(seq_hit)
  );

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = {6'b0, load_q, mode_q};
      A_STAT:  reg_rdata = {7'b0, wake_q};
      A_DEPTH: reg_rdata = 8'(depth_q);
      A_TOL:   reg_rdata = 8'(tol_q);
      A_COUNT: reg_rdata = 8'(count_q);
      A_RDATA: reg_rdata = rd_entry;
      A_RIDX:  reg_rdata = 8'(rd_idx_q);
      default: reg_rdata = 8'h00;
    endcase
  end

  assign wake = wake_q;
endmodule

// File: rtl/irwake_matcher_chk.sv
module irwake_matcher_chk #(
  parameter int N_ENTRIES = 16,
  parameter int CNT_W     = 5,
  parameter int IDX_W     = 4
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             mode_q,
  input logic             load_q,
  input logic [CNT_W-1:0] count_q,
  input logic [IDX_W-1:0] rd_idx_q,
  input logic             seq_hit,
  input logic             wake
);
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n_s)
    count_q <= CNT_W'(N_ENTRIES)); // R3

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr && reg_addr == 3'd5 && !load_q && mode_q) |=> $stable(count_q)); // R2

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[2] && !reg_wdata[0]) |=> (count_q == '0 && rd_idx_q == '0)); // R8

  AST_CLEAR_HELD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[2] && reg_wdata[0] && mode_q) |=> $stable(count_q)); // R8

  AST_HIT_WAKES: assert property (@(posedge clk) disable iff (!rst_n_s)
    seq_hit |=> wake); // R9

  AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(wake) |-> $past(seq_hit)); // R7

  AST_WAKE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr && reg_addr == 3'd1 && reg_wdata[0] && !seq_hit) |=> !wake); // R9

  AST_RIDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_idx_q == '0) || (CNT_W'(rd_idx_q) < count_q)); // R5
endmodule

bind irwake_matcher irwake_matcher_chk #(
  .N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W)
) i_chk (
  .clk(clk), .rst_n_s(rst_n_s), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mode_q(mode_q), .load_q(load_q), .count_q(count_q),
  .rd_idx_q(rd_idx_q), .seq_hit(seq_hit), .wake(wake)
);

// File: tb/test_irwake_matcher.sv
`timescale 1ns/1ps
module test_irwake_matcher;
  localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, DEPTH = 3'd2, TOL = 3'd3,
                         COUNT = 3'd4, WDATA = 3'd5, RDATA = 3'd6, RIDX = 3'd7;

  logic       clk = 1'b0;
  logic       rst_n, reg_wr, reg_rd, smp_valid;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, smp_data;
  logic       wake;

  int   n_checks = 0;
  int   n_bad    = 0;
  bit   done     = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  irwake_matcher i_irwake_matcher (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .smp_valid(smp_valid), .smp_data(smp_data), .wake(wake)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a read is in flight
  always @(negedge clk) begin
    if (reg_rd) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 8'h01, 8'h00);
      else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic smp(input logic [7:0] d);
    smp_valid = 1'b1; smp_data = d;
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  task automatic smp_wr(input logic [7:0] d, input logic [2:0] a, input logic [7:0] wd);
    smp_valid = 1'b1; smp_data = d;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = wd;
    @(posedge clk); #1;
    smp_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic seq4(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic [7:0] d);
    smp(a); smp(b); smp(c); smp(d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; smp_valid = 1'b0;
    reg_addr = '0; reg_wdata = '0; smp_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    check("R1 wake after reset", {7'b0, wake}, 8'h00);
    rd(CTRL, 8'h00, "R1 ctrl");   rd(STAT, 8'h00, "R1 status");
    rd(DEPTH, 8'h00, "R1 depth"); rd(TOL, 8'h00, "R1 tol");
    rd(COUNT, 8'h00, "R1 count"); rd(RIDX, 8'h00, "R1 ridx");

    // write gate
    wr(WDATA, 8'h85);
    rd(COUNT, 8'h00, "R2 write without load enable");
    wr(CTRL, 8'h02);
    wr(WDATA, 8'h05);
    wr(WDATA, 8'h80);
    rd(COUNT, 8'h00, "R3 space-first and zero-length rejected");
    wr(WDATA, 8'h88); wr(WDATA, 8'h10); wr(WDATA, 8'h84); wr(WDATA, 8'h20);
    rd(COUNT, 8'h04, "R2 four entries loaded");

    // readback with wrap
    rd(RIDX, 8'h00, "R5 index start");
    rd(RDATA, 8'h88, "R5 entry0");
    rd(RIDX, 8'h01, "R5 index advanced");
    rd(RDATA, 8'h10, "R5 entry1");
    rd(RDATA, 8'h84, "R5 entry2");
    rd(RDATA, 8'h20, "R5 entry3");
    rd(RIDX, 8'h00, "R5 index wrapped");

    // exact match
    wr(DEPTH, 8'h04); wr(TOL, 8'h01); wr(CTRL, 8'h01);
    smp(8'h88); smp(8'h10); smp(8'h84);
    check("R7 no wake before depth reached", {7'b0, wake}, 8'h00);
    smp(8'h20);
    check("R7 wake on exact match", {7'b0, wake}, 8'h01);
    rd(STAT, 8'h01, "R9 status mirrors wake");
    wr(STAT, 8'hFE);
    check("R9 writing zero to bit0 keeps wake", {7'b0, wake}, 8'h01);
    wr(STAT, 8'h01);
    check("R9 write-one clears wake", {7'b0, wake}, 8'h00);

    // one-period slack
    seq4(8'h89, 8'h0F, 8'h85, 8'h21);
    check("R6 durations within one period match", {7'b0, wake}, 8'h01);
    wr(STAT, 8'h01);

    // flag mismatch plus duration off by three: two misses
    seq4(8'h88, 8'h90, 8'h84, 8'h23);
    check("R6 flag and far duration mismatch", {7'b0, wake}, 8'h00);
    seq4(8'h88, 8'h10, 8'h04, 8'h20);
    check("R7 one miss within tolerance", {7'b0, wake}, 8'h01);

    // same-cycle set and clear
    smp(8'h88); smp(8'h10); smp(8'h84);
    smp_wr(8'h20, STAT, 8'h01);
    check("R9 hit wins over clear", {7'b0, wake}, 8'h01);
    smp(8'h88); smp(8'h7F); smp(8'h84);
    smp_wr(8'h7F, STAT, 8'h01);
    check("R9 clear with failing sequence", {7'b0, wake}, 8'h00);

    // restart on control write
    smp(8'h88); smp(8'h10);
    wr(CTRL, 8'h01);
    seq4(8'h88, 8'h10, 8'h84, 8'h20);
    check("R10 sequence restarts after ctrl write", {7'b0, wake}, 8'h01);
    wr(STAT, 8'h01);

    // depth beyond stored entries
    wr(DEPTH, 8'h06);
    seq4(8'h88, 8'h10, 8'h84, 8'h20); smp(8'h88); smp(8'h88);
    check("R7 positions past count mismatch", {7'b0, wake}, 8'h00);
    wr(TOL, 8'h02);
    seq4(8'h88, 8'h10, 8'h84, 8'h20); smp(8'h88); smp(8'h88);
    check("R7 tolerance two absorbs them", {7'b0, wake}, 8'h01);
    wr(STAT, 8'h01);
    wr(DEPTH, 8'h00);
    seq4(8'h88, 8'h10, 8'h84, 8'h20);
    check("R7 zero depth never wakes", {7'b0, wake}, 8'h00);

    // clear gating
    wr(CTRL, 8'h05);
    rd(COUNT, 8'h04, "R8 clear ignored in compare mode");
    rd(CTRL, 8'h01, "R8 clear bit reads zero");
    rd(RDATA, 8'h88, "R5 read before clear");
    wr(CTRL, 8'h04);
    rd(COUNT, 8'h00, "R8 clear empties store");
    rd(RIDX, 8'h00, "R8 clear resets index");

    // learning capture
    smp(8'h0A); smp(8'h8A); smp(8'h00); smp(8'h15);
    rd(COUNT, 8'h02, "R4 captured two legal samples");
    rd(RDATA, 8'h8A, "R4 captured entry0");
    rd(RDATA, 8'h15, "R4 captured entry1");
    wr(CTRL, 8'h02);
    smp(8'h99);
    rd(COUNT, 8'h02, "R4 no capture while load enabled");

    // fill to capacity
    for (int i = 0; i < 14; i++) wr(WDATA, 8'(8'h20 + i));
    rd(COUNT, 8'h10, "R3 store full");
    wr(WDATA, 8'h55);
    rd(COUNT, 8'h10, "R3 write to full store dropped");
    rd(RDATA, 8'h8A, "R5 read full entry0");
    rd(RDATA, 8'h15, "R5 read full entry1");
    rd(RDATA, 8'h20, "R5 read full entry2");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule